// File: doc/BRIEF.md
# Write-Spacing Command Monitor

This block watches a decoded memory command stream, one command per clock, and checks every command issued after a write against the rules that govern what may follow a write burst. It tracks only the most recent write: its bank, its burst length (4 or 8 beats) and whether it carried automatic precharge. It counts the cycles since that write and decides, for each new command, whether the command cuts the burst illegally, comes too early for a read or precharge to the written bank, or comes too soon after an auto-precharged write to another bank.

Distances are counted in clock edges. A command sampled on the edge right after the write has distance d = 1. The write data is taken to end at E = (CL-1) + BL/2 clocks after the write. A violation is reported one clock after the offending command as a single-cycle pulse with a one-hot reason code. A separate level output stays high while the write data of the last write is still in flight.

Top module: `wr_spacing_mon`

## Requirements
- R1: After reset, `viol` and `viol_code` are 0 and `wr_busy` is 0. All timers start expired, so the first command after reset is never flagged.
- R2: In the window d < BL/2 after a BL4 write, any non-NOP command to the same bank is flagged. A write at odd d gives code 0x01. Any other command gives code 0x02.
- R3: In the window d < 4 after a BL8 write without auto-precharge, a write to the same bank at d = 2 is legal. A write at d = 1 or 3 gives 0x01. Any non-write, non-NOP command gives 0x02.
- R4: After a BL8 write with auto-precharge, nothing may cut the burst. A same-bank write at d = 2 gives 0x02, a same-bank write at odd d gives 0x01, and any other same-bank command in the window gives 0x02.
- R5: A same-bank write at d = BL/2 or later is never flagged, so back-to-back bursts can be seamless.
- R6: A same-bank READ or READ-AP outside the burst window with d < E + max(2, TWR_TO_RD) gives code 0x04.
- R7: A same-bank PRECHARGE outside the burst window with d < E + WR_RECOVERY gives code 0x08.
- R8: When the last write carried auto-precharge, a read to another bank with d < E + TWR_TO_RD gives 0x10. A write to another bank with d < BL/2 also gives 0x10. PRECHARGE or ACTIVATE to another bank is never flagged.
- R9: Commands to another bank after a write without auto-precharge are never flagged. A same-bank ACTIVATE outside the burst window is never flagged.
- R10: `viol` and `viol_code` are registered. They describe the command sampled on the previous edge, and `viol_code` has at most one bit set.
- R11: `wr_busy` is high while 1 <= d <= E, with d measured from the last write to the next edge.
- R12: NOP is never flagged. NOP only advances the timers.

Command encoding on `cmd`: 0 NOP, 1 WRITE, 2 WRITE with auto-precharge, 3 READ, 4 READ with auto-precharge, 5 PRECHARGE, 6 ACTIVATE. The `bl8` input is 1 for BL8 and 0 for BL4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Decoded command |
| bank | input | $clog2(NBANK) | Target bank of the command |
| bl8 | input | 1 | Burst length of a write: 1 = 8 beats, 0 = 4 beats |
| viol | output | 1 | One-cycle pulse for a rule break by the previous command |
| viol_code | output | 5 | One-hot reason for the violation |
| wr_busy | output | 1 | Write data of the last write still in flight |

## Verification
The hardest cases to reach from the ports are the edges of each window. Examples are a same-bank read exactly one clock before the read-after-write limit expires, and a BL8 write cut at d = 2 whose legality depends on the earlier write's auto-precharge flag. The stimulus drives directed sequences that place commands at each boundary distance. It then runs a long random stream that uses only two banks, a NOP-heavy mix and random burst lengths, so that same-bank and other-bank commands land at every distance across all windows. A behavioural model predicts the outputs on every clock.

// File: rtl/wr_spacing_pkg.sv
package wr_spacing_pkg;

   typedef enum logic [2:0] {
      C_NOP  = 3'd0,
      C_WR   = 3'd1,
      C_WRA  = 3'd2,
      C_RD   = 3'd3,
      C_RDA  = 3'd4,
      C_PRE  = 3'd5,
      C_ACT  = 3'd6
   } mcmd_e;

   localparam int CODE_W   = 5;
   localparam int B_WSPC   = 0;   // write-to-write spacing
   localparam int B_TRUNC  = 1;   // illegal cut of a burst
   localparam int B_RDGAP  = 2;   // read after write too soon
   localparam int B_RECOV  = 3;   // precharge before write recovery
   localparam int B_XAP    = 4;   // cross-bank after auto-precharge write

endpackage

// File: rtl/wr_age_track.sv
module wr_age_track #(
   parameter int CL     = 4,
   parameter int BANK_W = 3,
   parameter int SAT    = 12,
   parameter int AGE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_seen,
   input  logic              ap_seen,
   input  logic [BANK_W-1:0] bank_in,
   input  logic              bl8_in,
   output logic [AGE_W-1:0]  age,
   output logic [BANK_W-1:0] last_bank,
   output logic              last_bl8,
   output logic              last_ap,
   output logic              busy
);

   localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(SAT);
   localparam logic [AGE_W-1:0] END4    = AGE_W'(CL - 1 + 2);
   localparam logic [AGE_W-1:0] END8    = AGE_W'(CL - 1 + 4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age       <= AGE_SAT;
         last_bank <= '0;
         last_bl8  <= 1'b0;
         last_ap   <= 1'b0;
      end else if (wr_seen) begin
         age       <= AGE_W'(1);
         last_bank <= bank_in;
         last_bl8  <= bl8_in;
         last_ap   <= ap_seen;
      end else if (age != AGE_SAT) begin
         age       <= age + AGE_W'(1);
      end
   end

   assign busy = (age <= (last_bl8 ? END8 : END4));

   assert_busy_after_wr_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |=> busy);

endmodule

// File: rtl/wr_rule_eval.sv
module wr_rule_eval
   import wr_spacing_pkg::*;
#(
   parameter int CL     = 4,
   parameter int TWTR   = 2,
   parameter int TWR    = 4,
   parameter int BANK_W = 3,
   parameter int AGE_W  = 4
) (
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [AGE_W-1:0]  age,
   input  logic [BANK_W-1:0] last_bank,
   input  logic              last_bl8,
   input  logic              last_ap,
   output logic [CODE_W-1:0] raw
);

   localparam int TWTR_E = (TWTR > 2) ? TWTR : 2;

   localparam logic [AGE_W-1:0] HALF4 = AGE_W'(2);
   localparam logic [AGE_W-1:0] HALF8 = AGE_W'(4);
   localparam logic [AGE_W-1:0] RD4   = AGE_W'(CL - 1 + 2 + TWTR_E);
   localparam logic [AGE_W-1:0] RD8   = AGE_W'(CL - 1 + 4 + TWTR_E);
   localparam logic [AGE_W-1:0] PR4   = AGE_W'(CL - 1 + 2 + TWR);
   localparam logic [AGE_W-1:0] PR8   = AGE_W'(CL - 1 + 4 + TWR);
   localparam logic [AGE_W-1:0] XR4   = AGE_W'(CL - 1 + 2 + TWTR);
   localparam logic [AGE_W-1:0] XR8   = AGE_W'(CL - 1 + 4 + TWTR);
   localparam logic [AGE_W-1:0] CUT8  = AGE_W'(2);

   mcmd_e c;
   logic  is_wr, is_rd, is_pre, same, in_win, cut_ok;
   logic [AGE_W-1:0] half, rd_lim, pr_lim, xr_lim;

   assign c      = mcmd_e'(cmd);
   assign is_wr  = (c == C_WR)  || (c == C_WRA);
   assign is_rd  = (c == C_RD)  || (c == C_RDA);
   assign is_pre = (c == C_PRE);
   assign same   = (bank == last_bank);
   assign half   = last_bl8 ? HALF8 : HALF4;
   assign rd_lim = last_bl8 ? RD8 : RD4;
   assign pr_lim = last_bl8 ? PR8 : PR4;
   assign xr_lim = last_bl8 ? XR8 : XR4;
   assign in_win = (age < half);
   assign cut_ok = last_bl8 && !last_ap && (age == CUT8);

   always_comb begin
      raw = '0;
      if (c != C_NOP) begin
         if (same) begin
            if (in_win) begin
               if (is_wr) begin
                  if (!cut_ok) begin
                     if (age[0]) raw[B_WSPC]  = 1'b1;
                     else        raw[B_TRUNC] = 1'b1;
                  end
               end else begin
                  raw[B_TRUNC] = 1'b1;
               end
            end else begin
               if (is_rd  && (age < rd_lim)) raw[B_RDGAP] = 1'b1;
               if (is_pre && (age < pr_lim)) raw[B_RECOV] = 1'b1;
            end
         end else if (last_ap) begin
            if (is_rd && (age < xr_lim)) raw[B_XAP] = 1'b1;
            if (is_wr && in_win)         raw[B_XAP] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/wr_code_prio.sv
module wr_code_prio #(
   parameter int W = 5
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] onehot
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_first
         assign onehot[i] = raw[i];
      end else begin : g_rest
         assign onehot[i] = raw[i] & ~(|raw[i-1:0]);
      end
   end

endmodule

// File: rtl/wr_spacing_mon.sv
module wr_spacing_mon
   import wr_spacing_pkg::*;
#(
   parameter int NBANK = 8,
   parameter int CL    = 4,
   parameter int TWTR  = 2,
   parameter int TWR   = 4,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic              bl8,
   output logic              viol,
   output logic [4:0]        viol_code,
   output logic              wr_busy
);

   localparam int TWTR_E = (TWTR > 2) ? TWTR : 2;
   localparam int HOLD_A = (TWR > TWTR_E) ? TWR : TWTR_E;
   localparam int HOLD   = (HOLD_A > TWTR) ? HOLD_A : TWTR;
   localparam int SAT    = CL - 1 + 4 + HOLD + 1;
   localparam int AGE_W  = $clog2(SAT + 1);

   if (CL < 2 || CL > 16) begin : g_bad_cl
      $error("wr_spacing_mon: CL out of range");
   end
   if (TWTR < 1 || TWR < 1) begin : g_bad_t
      $error("wr_spacing_mon: timing counts must be at least 1");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nb
      $error("wr_spacing_mon: NBANK must be a power of two >= 2");
   end
   if (CODE_W != 5) begin : g_bad_cw
      $error("wr_spacing_mon: code width mismatch");
   end

   logic              wr_seen, ap_seen;
   logic [AGE_W-1:0]  age;
   logic [BANK_W-1:0] last_bank;
   logic              last_bl8, last_ap;
   logic [CODE_W-1:0] raw, onehot;

   assign wr_seen = (cmd == 3'(C_WR)) || (cmd == 3'(C_WRA));
   assign ap_seen = (cmd == 3'(C_WRA));

   wr_age_track #(.CL(CL), .BANK_W(BANK_W), .SAT(SAT), .AGE_W(AGE_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_seen   (wr_seen),
      .ap_seen   (ap_seen),
      .bank_in   (bank),
      .bl8_in    (bl8),
      .age       (age),
      .last_bank (last_bank),
      .last_bl8  (last_bl8),
      .last_ap   (last_ap),
      .busy      (wr_busy)
   );

   wr_rule_eval #(.CL(CL), .TWTR(TWTR), .TWR(TWR), .BANK_W(BANK_W), .AGE_W(AGE_W)) u_rules (
      .cmd       (cmd),
      .bank      (bank),
      .age       (age),
      .last_bank (last_bank),
      .last_bl8  (last_bl8),
      .last_ap   (last_ap),
      .raw       (raw)
   );

   wr_code_prio #(.W(CODE_W)) u_prio (
      .raw    (raw),
      .onehot (onehot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= '0;
      end else begin
         viol      <= |onehot;
         viol_code <= onehot;
      end
   end

   assert_code_onehot_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(viol_code));

   assert_nop_quiet_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'(C_NOP)) |=> !viol);

   assert_rdgap_only_read_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      raw[B_RDGAP] |-> ((cmd == 3'(C_RD)) || (cmd == 3'(C_RDA))));

   assert_recov_only_pre_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      raw[B_RECOV] |-> (cmd == 3'(C_PRE)));

   assert_xap_other_bank_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      raw[B_XAP] |-> (bank != last_bank));

endmodule

// File: tb/tb_wr_spacing_mon.sv
module tb_wr_spacing_mon;

   localparam int CL = 4, TWTR = 2, TWR = 4;
   localparam logic [2:0] NOP = 0, WR = 1, WRA = 2, RD = 3, RDA = 4, PRE = 5, ACT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = NOP;
   logic [2:0] bank = '0;
   logic       bl8 = 1'b0;
   logic       viol;
   logic [4:0] viol_code;
   logic       wr_busy;

   int vectors = 0, errors = 0, cyc = 0;
   int lw = -1000000, lbank = 0;
   bit lbl8 = 0, lap = 0, armed = 0;
   logic [4:0] exp_code = '0;
   bit exp_busy = 0;

   always #10 clk = ~clk;

   wr_spacing_mon #(.NBANK(8), .CL(CL), .TWTR(TWTR), .TWR(TWR)) dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .bl8(bl8),
      .viol(viol), .viol_code(viol_code), .wr_busy(wr_busy)
   );

   function automatic string req_of(logic [4:0] c);
      if (c[0]) return "R3";
      if (c[1]) return "R2";
      if (c[2]) return "R6";
      if (c[3]) return "R7";
      if (c[4]) return "R8";
      return "R9";
   endfunction

   // behavioural reference
   always @(posedge clk) begin
      int d, half, dend, tw;
      bit is_w, is_r;
      armed = 1;
      if (!rst_n) begin
         lw = -1000000; lbank = 0; lbl8 = 0; lap = 0;
         exp_code = '0; exp_busy = 0;
      end else begin
         d    = cyc - lw;
         half = lbl8 ? 4 : 2;
         dend = CL - 1 + half;
         tw   = (TWTR > 2) ? TWTR : 2;
         is_w = (cmd == WR) || (cmd == WRA);
         is_r = (cmd == RD) || (cmd == RDA);
         exp_code = '0;
         if (cmd != NOP) begin
            if (int'(bank) == lbank) begin
               if (d < half) begin
                  if (is_w) begin
                     if (!(lbl8 && !lap && d == 2))
                        exp_code = (d % 2 == 1) ? 5'h01 : 5'h02;
                  end else exp_code = 5'h02;
               end else if (is_r && d < dend + tw) exp_code = 5'h04;
               else if (cmd == PRE && d < dend + TWR) exp_code = 5'h08;
            end else if (lap) begin
               if (is_r && d < dend + TWTR) exp_code = 5'h10;
               if (is_w && d < half)        exp_code = 5'h10;
            end
         end
         if (is_w) begin
            lw = cyc; lbank = int'(bank); lbl8 = bl8; lap = (cmd == WRA);
         end
         exp_busy = ((cyc + 1 - lw) <= (CL - 1 + (lbl8 ? 4 : 2)));
      end
      cyc++;
   end

   // compare on every clock, away from the edge
   always @(negedge clk) begin
      if (armed) begin
         vectors++;
         if (viol_code !== exp_code || viol !== (exp_code != 0)) begin
            errors++;
            $display("FAIL %s cyc %0d: viol=%0b code=%02h expected viol=%0b code=%02h",
                     req_of(exp_code | viol_code), cyc, viol, viol_code, exp_code != 0, exp_code);
         end
         vectors++;
         if (wr_busy !== exp_busy) begin
            errors++;
            $display("FAIL R11 cyc %0d: wr_busy=%0b expected %0b", cyc, wr_busy, exp_busy);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R1 watchdog: cycles %0d expected below 150000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic step(input logic [2:0] c, input int b, input bit l);
      @(negedge clk);
      cmd = c; bank = 3'(b); bl8 = l;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(NOP, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state checked explicitly, then first command is a read
      vectors++;
      if (viol !== 1'b0 || viol_code !== 5'h00 || wr_busy !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: viol=%0b code=%02h busy=%0b expected 0 00 0", viol, viol_code, wr_busy);
      end
      step(RD, 0, 0); idle(2);
      // R2: BL4 cut by write at d=1 and by read at d=1
      step(WR, 0, 0); step(WR, 0, 0); idle(12);
      step(WR, 0, 0); step(RD, 0, 0); idle(12);
      // R3: BL8 legal cut at d=2, illegal at d=1 and d=3, precharge cut
      step(WR, 1, 1); step(NOP, 0, 0); step(WR, 1, 1); idle(12);
      step(WR, 1, 1); step(WR, 1, 1); idle(12);
      step(WR, 1, 1); idle(2); step(WR, 1, 0); idle(12);
      step(WR, 1, 1); step(PRE, 1, 0); idle(12);
      // R4: BL8 with auto-precharge cut at d=2
      step(WRA, 2, 1); step(NOP, 0, 0); step(WR, 2, 0); idle(12);
      // R5: seamless BL4 writes at d=2
      step(WR, 0, 0); step(NOP, 0, 0); step(WR, 0, 0); step(NOP, 0, 0); step(WR, 0, 0); idle(12);
      // R6: read at last illegal and first legal distance
      step(WR, 0, 0); idle(5); step(RD, 0, 0); idle(12);
      step(WR, 0, 0); idle(6); step(RDA, 0, 0); idle(12);
      // R7: precharge inside and at end of recovery
      step(WR, 0, 1); idle(9); step(PRE, 0, 0); idle(12);
      step(WR, 0, 1); idle(10); step(PRE, 0, 0); idle(12);
      // R8: cross-bank after auto-precharge write
      step(WRA, 0, 0); step(NOP, 0, 0); step(RD, 1, 0); idle(12);
      step(WRA, 0, 1); step(WR, 1, 0); step(ACT, 2, 0); step(PRE, 3, 0); idle(12);
      // R9: cross-bank after plain write, same-bank activate after window
      step(WR, 0, 1); step(RD, 1, 0); step(WR, 2, 0); idle(4); step(ACT, 0, 0); idle(12);
      // R12/R10: long random stream with NOP-heavy mix on two banks
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [2:0] c;
         r = $urandom_range(0, 15);
         c = (r < 7) ? NOP : 3'($urandom_range(1, 6));
         step(c, $urandom_range(0, 1), 1'($urandom_range(0, 1)));
      end
      idle(4);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule